// File: doc/BRIEF.md
# Conditional Branch Resolver

This block decides whether a conditional near branch is taken and produces the address of the next instruction to fetch. A request carries a four-bit condition selector, five status flags (overflow, carry, zero, sign, parity), the address of the instruction that follows the branch, a signed 32-bit relative displacement and a flag that marks a 16-bit operand size. The selector picks one of sixteen conditions. Odd selectors are the complements of the even selector just below them. The set covers single-flag tests, unsigned below-or-equal, and signed less-than and less-or-equal.

When the condition holds, the new pointer is the sign-extended displacement added to the address of the next instruction. With a 16-bit operand size, only the low 16 bits of that sum are kept. When the condition fails, the pointer is the address of the next instruction. The decision and the pointer are registered, and a valid strobe marks them one clock after the request. Producing the flags and decoding instructions belong to other blocks.

Top module: `brres_top`

## Requirements
- R1: Selectors 0/1 are taken when overflow is set/clear; 2/3 when carry is set/clear; 4/5 when zero is set/clear.
- R2: Selectors 8/9 are taken when sign is set/clear; 10/11 when parity is set/clear.
- R3: Selector 6 is taken when carry or zero is set; selector 7 is taken when both are clear.
- R4: Selector 12 is taken when sign differs from overflow; selector 13 is taken when they match.
- R5: Selector 14 is taken when zero is set or sign differs from overflow; selector 15 is taken when zero is clear and sign equals overflow.
- R6: A taken result's pointer equals the next-instruction address plus the displacement sign-extended to the pointer width, with wrap-around modulo 2^64.
- R7: When the 16-bit operand flag is set on a taken branch, bits 63..16 of the result pointer are zero and bits 15..0 equal the low 16 bits of the sum.
- R8: A not-taken result's pointer equals the next-instruction address unchanged, whatever the operand-size flag and displacement.
- R9: `res_vld` pulses high for exactly one cycle, one clock after each cycle with `req_vld` high. `res_taken` and `res_ptr` hold their values while `res_vld` is low.
- R10: After reset, `res_vld` and `res_taken` are 0 and `res_ptr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | 1 | Request strobe |
| req_cond | input | 4 | Condition selector |
| req_flags | input | 5 | Flags {PF,SF,ZF,CF,OF} at bits 4..0 |
| req_next | input | 64 | Address of the instruction after the branch |
| req_disp | input | 32 | Signed displacement |
| req_os16 | input | 1 | 16-bit operand size |
| res_vld | output | 1 | Result strobe |
| res_taken | output | 1 | Condition held |
| res_ptr | output | 64 | Next fetch pointer |

## Verification
The hardest cases are the signed conditions (selectors 12 to 15) and the carry across the upper half of the pointer. The flag-dependent results only differ when sign and overflow disagree in combination with zero, and a wrong sign extension only shows when a negative displacement has to borrow through bit 32 and above. The stimulus sweeps all sixteen selectors over all 32 flag combinations with back-to-back requests. It then sends negative displacements with next-addresses that sit just above a 2^32 boundary, with 16-bit truncation both on and off.

// File: rtl/brres_pkg.sv
package brres_pkg;
  localparam int FLAG_W = 5;
  localparam int OF_B = 0;
  localparam int CF_B = 1;
  localparam int ZF_B = 2;
  localparam int SF_B = 3;
  localparam int PF_B = 4;
endpackage

// File: rtl/brres_cond.sv
module brres_cond
  import brres_pkg::*;
(
  input  logic [3:0]        cond,
  input  logic [FLAG_W-1:0] flags,
  output logic              hit
);
  logic base;
  logic lt;
  assign lt = flags[SF_B] ^ flags[OF_B];
  always_comb begin
    case (cond[3:1])
      3'd0: base = flags[OF_B];
      3'd1: base = flags[CF_B];
      3'd2: base = flags[ZF_B];
      3'd3: base = flags[CF_B] | flags[ZF_B];
      3'd4: base = flags[SF_B];
      3'd5: base = flags[PF_B];
      3'd6: base = lt;
      default: base = flags[ZF_B] | lt;
    endcase
  end
  assign hit = base ^ cond[0];
endmodule

// File: rtl/brres_tgt.sv
module brres_tgt #(
  parameter int PTR_W = 64,
  parameter int DISP_W = 32,
  parameter int NARROW_W = 16
) (
  input  logic [PTR_W-1:0]  nxt,
  input  logic [DISP_W-1:0] disp,
  input  logic              narrow,
  output logic [PTR_W-1:0]  tgt
);
  localparam int EXT_W = PTR_W - DISP_W;
  logic [PTR_W-1:0] sum;
  assign sum = nxt + {{EXT_W{disp[DISP_W-1]}}, disp};
  assign tgt = narrow ? {{(PTR_W-NARROW_W){1'b0}}, sum[NARROW_W-1:0]} : sum;
endmodule

// File: rtl/brres_top.sv
module brres_top
  import brres_pkg::*;
#(
  parameter int PTR_W = 64,
  parameter int DISP_W = 32,
  parameter int NARROW_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_vld,
  input  logic [3:0]        req_cond,
  input  logic [FLAG_W-1:0] req_flags,
  input  logic [PTR_W-1:0]  req_next,
  input  logic [DISP_W-1:0] req_disp,
  input  logic              req_os16,
  output logic              res_vld,
  output logic              res_taken,
  output logic [PTR_W-1:0]  res_ptr
);
  logic             hit;
  logic [PTR_W-1:0] tgt;

  brres_cond u_cond (.cond(req_cond), .flags(req_flags), .hit(hit));
  brres_tgt #(.PTR_W(PTR_W), .DISP_W(DISP_W), .NARROW_W(NARROW_W)) u_tgt (
    .nxt(req_next), .disp(req_disp), .narrow(req_os16), .tgt(tgt));

  always_ff @(posedge clk) begin
    if (rst) begin
      res_vld   <= 1'b0;
      res_taken <= 1'b0;
      res_ptr   <= '0;
    end else begin
      res_vld <= req_vld;
      if (req_vld) begin
        res_taken <= hit;
        res_ptr   <= hit ? tgt : req_next;
      end
    end
  end

  p_strobe_r9: assert property (@(posedge clk) disable iff (rst)
    res_vld == $past(req_vld));
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(req_vld) |-> ($stable(res_ptr) && $stable(res_taken)));
  p_notaken_r8: assert property (@(posedge clk) disable iff (rst)
    (res_vld && !res_taken) |-> res_ptr == $past(req_next));
  p_narrow_r7: assert property (@(posedge clk) disable iff (rst)
    (res_vld && res_taken && $past(req_os16)) |-> res_ptr[PTR_W-1:NARROW_W] == '0);
  p_pair_r1: assert property (@(posedge clk) disable iff (rst)
    (req_vld && req_cond == 4'd0) |=> res_taken == $past(req_flags[OF_B]));
  p_sgn_r4: assert property (@(posedge clk) disable iff (rst)
    (req_vld && req_cond == 4'd12) |=> res_taken == ($past(req_flags[SF_B]) != $past(req_flags[OF_B])));
endmodule

// File: tb/brres_top_test.sv
module brres_top_test;
  logic clk = 0, rst = 1, req_vld = 0, req_os16 = 0;
  logic [3:0] req_cond = 0;
  logic [4:0] req_flags = 0;
  logic [63:0] req_next = 0;
  logic [31:0] req_disp = 0;
  logic res_vld, res_taken;
  logic [63:0] res_ptr;
  int n_run = 0, n_fail = 0;
  int n_vld = 0;
  typedef struct { logic tk; logic [63:0] p; string rq; } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;

  brres_top uut (.clk, .rst, .req_vld, .req_cond, .req_flags, .req_next,
    .req_disp, .req_os16, .res_vld, .res_taken, .res_ptr);

  function automatic logic model(input logic [3:0] c, input logic [4:0] f);
    logic o, cy, z, s, p, r;
    o = f[0]; cy = f[1]; z = f[2]; s = f[3]; p = f[4];
    case (c)
      0: r = o;   1: r = !o;  2: r = cy;  3: r = !cy;
      4: r = z;   5: r = !z;  6: r = cy || z; 7: r = !cy && !z;
      8: r = s;   9: r = !s;  10: r = p;  11: r = !p;
      12: r = s != o; 13: r = s == o;
      14: r = z || (s != o); default: r = !z && (s == o);
    endcase
    return r;
  endfunction

  function automatic string tag(input logic [3:0] c);
    if (c < 6) return "R1";
    if (c < 8) return "R3";
    if (c < 12) return "R2";
    if (c < 14) return "R4";
    return "R5";
  endfunction

  task automatic drive(input logic [3:0] c, input logic [4:0] f, input logic [63:0] nx,
                       input logic [31:0] d, input logic n16);
    exp_t e;
    logic [63:0] s;
    e.tk = model(c, f);
    s = nx + {{32{d[31]}}, d};
    if (n16) s = {48'h0, s[15:0]};
    e.p = e.tk ? s : nx;
    e.rq = !e.tk ? {tag(c), "/R8"} : (n16 ? {tag(c), "/R7"} : {tag(c), "/R6"});
    q.push_back(e);
    @(negedge clk);
    req_vld = 1; req_cond = c; req_flags = f; req_next = nx; req_disp = d; req_os16 = n16;
    @(negedge clk);
    req_vld = 0;
  endtask

  task automatic check(input bit ok, input string rq, input logic [63:0] a, input logic [63:0] e);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, a, e);
    end
  endtask

  always @(negedge clk) if (!rst && res_vld) begin
    exp_t e;
    n_vld++;
    if (q.size() == 0) check(0, "R9", 64'(res_vld), 0);
    else begin
      e = q.pop_front();
      check(res_taken == e.tk, e.rq, 64'(res_taken), 64'(e.tk));
      check(res_ptr == e.p, e.rq, res_ptr, e.p);
    end
  end

  initial begin
    #200000;
    check(0, "watchdog", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] keep;
    repeat (3) @(negedge clk);
    check(res_vld == 0 && res_taken == 0 && res_ptr == 0, "R10", res_ptr, 0);
    rst = 0;
    for (int c = 0; c < 16; c++)
      for (int f = 0; f < 32; f++)
        drive(4'(c), 5'(f), 64'h0000_0001_0000_0010 + 64'(f), 32'hFFFF_FF00 + 32'(c), 1'(f & 1));
    // back-to-back requests
    @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      exp_t e;
      e.tk = model(4'd14, 5'(k));
      e.p = e.tk ? 64'h0000_0002_0000_0000 - 64'd4 : 64'h0000_0002_0000_0000;
      e.rq = "R9/R5";
      q.push_back(e);
      req_vld = 1; req_cond = 14; req_flags = 5'(k); req_next = 64'h0000_0002_0000_0000;
      req_disp = 32'hFFFF_FFFC; req_os16 = 0;
      @(negedge clk);
    end
    req_vld = 0;
    // boundary: borrow across 2^32, wrap, narrow
    drive(4'd4, 5'b00100, 64'h0000_0001_0000_0000, 32'h8000_0000, 0);
    drive(4'd5, 5'b00000, 64'hFFFF_FFFF_FFFF_FFF0, 32'h0000_0020, 0);
    drive(4'd5, 5'b00000, 64'h1234_5678_9ABC_FFF0, 32'h0000_0020, 1);
    drive(4'd4, 5'b00000, 64'h1234_5678_9ABC_FFF0, 32'h7FFF_FFFF, 1);
    drive(4'd13, 5'b01001, 64'h0000_0000_0000_8000, 32'hFFFF_8000, 1);
    repeat (3) @(negedge clk);
    keep = res_ptr;
    repeat (4) @(negedge clk);
    check(res_ptr == keep && res_vld == 0, "R9", res_ptr, keep);
    check(q.size() == 0 && n_vld == 16*32 + 8 + 5, "R9", 64'(n_vld), 64'(16*32+13));
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule